// File: doc/BRIEF.md
# Address-Filtering Multidrop Serial Receiver

This block receives asynchronous serial frames from a line shared by several stations. Each frame carries a start bit, eight data bits, one station-flag bit and a stop bit. When the flag bit is 1, the frame names a destination station. When the flag bit is 0, the frame carries payload. The receiver holds a local station number on an input. It ignores all traffic until an address frame names that number, and from then on it delivers the payload frames that follow. The next address frame that names some other station puts the receiver back into skipping.

The line is sampled at sixteen times the bit rate, from a fixed divider of the system clock. A start bit that has gone back high by its midpoint is dropped as noise. Every later bit is taken at its centre. A delivered byte raises a ready flag and pulses a receive strobe. A low stop bit raises an error flag and pulses an error strobe. A delivered byte that arrives while the previous one is still unread raises an overrun flag, and the older byte is kept. A one-cycle acknowledge clears all three flags.

Top module: `mpx_addr_rx`

## Requirements
- R1: Out of reset the ready, error and overrun flags and both strobes are 0, `rx_byte` is 0, and the station is not selected.
- R2: A frame is a 0 start bit, then data bits 0 through 7 (least significant bit first), then the flag bit, then a 1 stop bit. A payload byte that is accepted appears unchanged on `rx_byte`.
- R3: While the station is not selected, payload frames (flag bit 0) leave `data_ready`, `rx_byte` and `rx_irq` untouched.
- R4: An address frame (flag bit 1) whose byte equals `own_id` selects the station. The address frame itself is not delivered: `data_ready` does not rise for it.
- R5: An address frame whose byte differs from `own_id` deselects the station. Payload frames that follow are skipped until a matching address frame arrives.
- R6: An accepted payload frame sets `data_ready` and pulses `rx_irq`. A cycle with `rd_ack` high clears `data_ready`.
- R7: A frame whose stop bit is sampled as 0 sets `frame_err` and pulses `err_irq`. Its byte is discarded, the selection is left as it was, and `rd_ack` clears `frame_err`.
- R8: A low pulse shorter than half a bit period on an idle line produces no frame, no flag and no strobe.
- R9: An accepted payload frame that arrives while `data_ready` is set raises `overrun` and leaves `rx_byte` holding the older byte. `rd_ack` clears `overrun`.
- R10: `rx_irq` and `err_irq` are single-cycle pulses, one per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Serial line, idle high |
| own_id | input | 8 | Local station number compared with address frames |
| rd_ack | input | 1 | One-cycle acknowledge: clears ready, error and overrun flags |
| rx_byte | output | 8 | Last payload byte delivered |
| data_ready | output | 1 | A delivered byte is waiting |
| frame_err | output | 1 | A frame ended with a low stop bit |
| overrun | output | 1 | A byte arrived while the previous one was still unread |
| rx_irq | output | 1 | One-cycle strobe for each delivered byte |
| err_irq | output | 1 | One-cycle strobe for each framing error |

## Verification
The assertions assume that `rx_line` is driven at a rate of `CLK_DIV*OVS` clocks per bit, that `own_id` stays constant while a frame is being received, and that `rd_ack` is a single-cycle pulse. The stimulus holds every line level for exactly one bit period, fixes the station number for the whole run, and issues acknowledges only as single-cycle pulses on an idle line between frames. The random phase draws address bytes, payloads, flag bits, bad stop bits and acknowledges from a seeded generator, so selection changes, overruns and errors occur in mixed order.

// File: rtl/mpx_rx_pkg.sv
package mpx_rx_pkg;
  localparam int DATA_W = 8;
  localparam int OVS    = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_FLAG,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              flag;
    logic              stop_ok;
  } rx_frame_t;
endpackage

// File: rtl/mpx_rx_frontend.sv
module mpx_rx_frontend #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic rst_sn,
  output logic rx_s,
  output logic os_tick
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [1:0]    rst_pipe;
  logic [1:0]    rx_pipe;
  logic [DW-1:0] div_q, div_d;
  logic          tick_d;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // line synchronizer, idle level is high
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rx_pipe <= 2'b11;
    else         rx_pipe <= {rx_pipe[0], rx_line};
  end
  assign rx_s = rx_pipe[1];

  always_comb begin
    tick_d = (div_q == DW'(CLK_DIV - 1));
    div_d  = tick_d ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      div_q   <= '0;
      os_tick <= 1'b0;
    end else begin
      div_q   <= div_d;
      os_tick <= tick_d;
    end
  end
endmodule

// File: rtl/mpx_rx_deframer.sv
module mpx_rx_deframer
  import mpx_rx_pkg::*;
#(
  parameter int OVS_N  = OVS,
  parameter int DBITS  = DATA_W
) (
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      os_tick,
  input  logic      rx_s,
  output logic      frm_vld,
  output rx_frame_t frm
);
  localparam int TW   = $clog2(OVS_N);
  localparam int BW   = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam int HALF = OVS_N / 2;

  rx_state_e        st_q, st_d;
  logic [TW-1:0]    tcnt_q, tcnt_d;
  logic [BW-1:0]    bidx_q, bidx_d;
  logic [DBITS-1:0] sh_q, sh_d;
  logic             flag_q, flag_d;
  logic             vld_d, stop_d;
  logic             mid_pt;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    flag_d = flag_q;
    vld_d  = 1'b0;
    stop_d = 1'b0;
    mid_pt = (tcnt_q == TW'(OVS_N - 1));
    case (st_q)
      ST_IDLE: begin
        if (os_tick && !rx_s) begin
          st_d   = ST_START;
          tcnt_d = '0;
        end
      end
      ST_START: begin
        if (os_tick) begin
          if (tcnt_q == TW'(HALF - 1)) begin
            tcnt_d = '0;
            bidx_d = '0;
            st_d   = rx_s ? ST_IDLE : ST_DATA;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (os_tick) begin
          if (mid_pt) begin
            tcnt_d = '0;
            sh_d   = {rx_s, sh_q[DBITS-1:1]};
            if (bidx_q == BW'(DBITS - 1)) st_d = ST_FLAG;
            else                          bidx_d = bidx_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_FLAG: begin
        if (os_tick) begin
          if (mid_pt) begin
            tcnt_d = '0;
            flag_d = rx_s;
            st_d   = ST_STOP;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (os_tick) begin
          if (mid_pt) begin
            tcnt_d = '0;
            vld_d  = 1'b1;
            stop_d = rx_s;
            st_d   = rx_s ? ST_IDLE : ST_WAITHI;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_WAITHI: begin
        if (rx_s) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      flag_q  <= 1'b0;
      frm_vld <= 1'b0;
      frm     <= '0;
    end else begin
      st_q    <= st_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      sh_q    <= sh_d;
      flag_q  <= flag_d;
      frm_vld <= vld_d;
      if (vld_d) begin
        frm.data    <= sh_q;
        frm.flag    <= flag_q;
        frm.stop_ok <= stop_d;
      end
    end
  end
endmodule

// File: rtl/mpx_rx_station.sv
module mpx_rx_station
  import mpx_rx_pkg::*;
#(
  parameter int DBITS = DATA_W
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             frm_vld,
  input  rx_frame_t        frm,
  input  logic [DBITS-1:0] own_id,
  input  logic             rd_ack,
  output logic [DBITS-1:0] rx_byte,
  output logic             data_ready,
  output logic             frame_err,
  output logic             overrun,
  output logic             rx_irq,
  output logic             err_irq,
  output logic             station_sel
);
  logic [DBITS-1:0] byte_d;
  logic             rdy_d, ferr_d, ovr_d, rirq_d, eirq_d, sel_d;
  logic             bad, addr, pay;

  always_comb begin
    byte_d = rx_byte;
    sel_d  = station_sel;
    rdy_d  = data_ready & ~rd_ack;
    ferr_d = frame_err  & ~rd_ack;
    ovr_d  = overrun    & ~rd_ack;
    rirq_d = 1'b0;
    eirq_d = 1'b0;
    bad    = frm_vld & ~frm.stop_ok;
    addr   = frm_vld &  frm.stop_ok &  frm.flag;
    pay    = frm_vld &  frm.stop_ok & ~frm.flag & station_sel;
    if (bad) begin
      ferr_d = 1'b1;
      eirq_d = 1'b1;
    end
    if (addr) sel_d = (frm.data == own_id);
    if (pay) begin
      if (data_ready && !rd_ack) begin
        ovr_d = 1'b1;
      end else begin
        byte_d = frm.data;
        rdy_d  = 1'b1;
        rirq_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rx_byte     <= '0;
      data_ready  <= 1'b0;
      frame_err   <= 1'b0;
      overrun     <= 1'b0;
      rx_irq      <= 1'b0;
      err_irq     <= 1'b0;
      station_sel <= 1'b0;
    end else begin
      rx_byte     <= byte_d;
      data_ready  <= rdy_d;
      frame_err   <= ferr_d;
      overrun     <= ovr_d;
      rx_irq      <= rirq_d;
      err_irq     <= eirq_d;
      station_sel <= sel_d;
    end
  end
endmodule

// File: rtl/mpx_addr_rx.sv
module mpx_addr_rx
  import mpx_rx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int OVS_N   = OVS,
  parameter int DBITS   = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic [DBITS-1:0] own_id,
  input  logic             rd_ack,
  output logic [DBITS-1:0] rx_byte,
  output logic             data_ready,
  output logic             frame_err,
  output logic             overrun,
  output logic             rx_irq,
  output logic             err_irq
);
  logic      rst_sn, rx_s, os_tick, frm_vld, station_sel;
  rx_frame_t frm;

  mpx_rx_frontend #(.CLK_DIV(CLK_DIV)) u_front (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .rst_sn(rst_sn), .rx_s(rx_s), .os_tick(os_tick)
  );

  mpx_rx_deframer #(.OVS_N(OVS_N), .DBITS(DBITS)) u_defr (
    .clk(clk), .rst_sn(rst_sn), .os_tick(os_tick), .rx_s(rx_s),
    .frm_vld(frm_vld), .frm(frm)
  );

  mpx_rx_station #(.DBITS(DBITS)) u_stn (
    .clk(clk), .rst_sn(rst_sn), .frm_vld(frm_vld), .frm(frm),
    .own_id(own_id), .rd_ack(rd_ack),
    .rx_byte(rx_byte), .data_ready(data_ready), .frame_err(frame_err),
    .overrun(overrun), .rx_irq(rx_irq), .err_irq(err_irq),
    .station_sel(station_sel)
  );
endmodule

// File: rtl/mpx_addr_rx_chk.sv
module mpx_addr_rx_chk #(
  parameter int DBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_ack,
  input logic [DBITS-1:0] rx_byte,
  input logic             data_ready,
  input logic             frame_err,
  input logic             rx_irq,
  input logic             err_irq,
  input logic             station_sel
);
  p_rx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);
  p_irq_sets_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> data_ready);
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> (!data_ready || rx_irq));
  p_err_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> frame_err);
  p_only_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(station_sel));
  p_byte_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && $past(data_ready) && !rx_irq) |-> $stable(rx_byte));
endmodule

bind mpx_addr_rx mpx_addr_rx_chk #(.DBITS(DBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .rx_byte(rx_byte),
  .data_ready(data_ready), .frame_err(frame_err), .rx_irq(rx_irq),
  .err_irq(err_irq), .station_sel(station_sel)
);

// File: tb/mpx_addr_rx_bench.sv
module mpx_addr_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int OVSR       = 16;
  localparam int BIT_CLKS   = DIV * OVSR;
  localparam logic [7:0] OWN = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_byte;
  logic       data_ready, frame_err, overrun, rx_irq, err_irq;

  int n_chk = 0, n_fail = 0, n_rxirq = 0, n_errirq = 0, cyc = 0;

  logic [7:0] m_byte = 8'h00;
  bit m_ready = 0, m_ferr = 0, m_ovr = 0, m_sel = 0;
  int m_rxirq = 0, m_errirq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpx_addr_rx #(.CLK_DIV(DIV)) u_mpx_addr_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .own_id(OWN), .rd_ack(rd_ack),
    .rx_byte(rx_byte), .data_ready(data_ready), .frame_err(frame_err),
    .overrun(overrun), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  always @(posedge clk) begin
    if (rx_irq)  n_rxirq  <= n_rxirq + 1;
    if (err_irq) n_errirq <= n_errirq + 1;
    cyc <= cyc + 1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    @(negedge clk);
    chk(req, "rx_byte",    rx_byte,    m_byte);
    chk(req, "data_ready", data_ready, m_ready);
    chk(req, "frame_err",  frame_err,  m_ferr);
    chk(req, "overrun",    overrun,    m_ovr);
    chk(req, "rx_irq count",  n_rxirq,  m_rxirq);
    chk(req, "err_irq count", n_errirq, m_errirq);
  endtask

  function automatic void model_frame(input logic [7:0] d, input bit f, input bit s);
    if (!s) begin
      m_ferr = 1; m_errirq++;
    end else if (f) begin
      m_sel = (d == OWN);
    end else if (m_sel) begin
      if (m_ready) m_ovr = 1;
      else begin m_byte = d; m_ready = 1; m_rxirq++; end
    end
  endfunction

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // start, data LSB first, flag bit, stop, then two idle bits
  task automatic send_frame(input logic [7:0] d, input bit f, input bit s);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    drive_bit(f);
    drive_bit(s);
    drive_bit(1'b1);
    drive_bit(1'b1);
    model_frame(d, f, s);
  endtask

  task automatic ack();
    @(negedge clk);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    m_ready = 0; m_ovr = 0; m_ferr = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1234_5678);
    repeat (5) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    compare_all("R1");

    send_frame(8'h33, 0, 1);           // unselected payload
    compare_all("R3");
    send_frame(8'h11, 1, 1);           // foreign address
    send_frame(8'h77, 0, 1);
    compare_all("R5");
    send_frame(OWN, 1, 1);             // own address, not delivered
    compare_all("R4");
    send_frame(8'hA5, 0, 1);
    compare_all("R2");
    chk("R6", "rx_irq after payload", n_rxirq, 1);
    ack();
    compare_all("R6");
    send_frame(8'h01, 0, 1);
    send_frame(8'h80, 0, 1);           // arrives while unread
    compare_all("R9");
    chk("R9", "kept older byte", rx_byte, 8'h01);
    ack();
    send_frame(8'h3C, 0, 0);           // low stop bit
    compare_all("R7");
    send_frame(8'h3D, 0, 1);           // selection survived the error
    compare_all("R7");
    ack();

    @(negedge clk);                    // short low glitch
    rx_line = 1'b0;
    repeat (BIT_CLKS/4) @(negedge clk);
    rx_line = 1'b1;
    repeat (3*BIT_CLKS) @(negedge clk);
    compare_all("R8");
    send_frame(8'hC3, 0, 1);
    compare_all("R8");
    ack();
    send_frame(8'hEE, 1, 1);
    send_frame(8'h42, 0, 1);
    compare_all("R5");
    send_frame(8'h42, 0, 1);
    compare_all("R3");

    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      bit f, s;
      f = ($urandom_range(0, 3) == 0);
      s = ($urandom_range(0, 9) != 0);
      d = $urandom_range(0, 255);
      if (f && $urandom_range(0, 1) == 1) d = OWN;
      send_frame(d, f, s);
      compare_all("R10");
      if ($urandom_range(0, 2) == 0) ack();
    end
    summary();
  end
endmodule